// File: doc/BRIEF.md
# I2C Master Target Address Controller

This block is the register slice on the master side of an I2C controller that tells the bit engine whom to address. It stores three things: a 10-bit target address, a flag choosing 7-bit or 10-bit addressing, and a pair of bits that replace normal addressing with a special command. The special command is either a general call or a START byte. Software reaches the slice through a simple register bus with a write strobe, a read strobe, an address, write data and read data. The read data is combinational.

The controller may already be running when software writes to the slice. The slice therefore decides whether each write may land, using four status inputs: controller enable, master mode selected, master transfer active, and TX FIFO empty. From the stored fields and the direction of the pending command, it produces the first address byte of the next transfer. In 10-bit mode it also produces a second byte and a flag saying that the second byte is needed.

General-call mode stays in force until software clears the special enable. While it is in force, only writes are legal, so a read command presented to the slice produces a one-cycle abort pulse.

Top module: `i2c_tgt_addr_ctl`

## Requirements
- R1: After reset, a read at the register offset returns 0x0000_1055. This means address bits [9:0] = 0x55, special enable bit 11 = 0, general-call/START select bit 10 = 0, and 10-bit select bit 12 = 1.
- R2: While the controller enable input is low, a write at byte offset 0x04 stores data bits [12:0] into the fields on the next clock edge.
- R3: Bits [31:13] of the read data are always zero, and writing ones into them changes nothing.
- R4: While the controller is enabled, a write lands only if master mode is selected, no master transfer is active, and the TX FIFO is empty. In every other case the write is dropped.
- R5: A write or read at any offset other than 0x04 has no effect. Read data is zero while no read is requested at 0x04.
- R6: With bit 11 = 0 and bit 12 = 0, the first address byte is {addr[6:0], rw}, with rw = 1 for a read. No second byte is flagged.
- R7: With bit 11 = 0 and bit 12 = 1, the first byte is {5'b11110, addr[9:8], rw}, the second byte is addr[7:0], and the two-byte flag is set.
- R8: With bit 11 = 1 and bit 10 = 0 (general call), the first byte is 0x00 whatever the address field holds. This mode persists until bit 11 is written to 0.
- R9: With bit 11 = 1 and bit 10 = 1 (START byte), the first byte is 0x01 and no second byte is flagged.
- R10: One cycle after a cycle in which a read command is valid in general-call mode, the abort output is high for exactly that cycle. It is never high after a write command, and never high outside general-call mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address on the register bus |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle as the read strobe |
| ctl_en | input | 1 | Controller enabled |
| mst_mode | input | 1 | Controller configured as master |
| mst_busy | input | 1 | Master transfer in progress |
| txf_empty | input | 1 | TX FIFO has no entries |
| cmd_valid | input | 1 | Next command is being presented |
| cmd_read | input | 1 | Presented command is a read (1) or write (0) |
| hdr_byte0 | output | 8 | First address byte for the transfer |
| hdr_byte1 | output | 8 | Second address byte (10-bit mode) |
| hdr_two | output | 1 | Second byte is required |
| gcall_mode | output | 1 | General-call mode is active |
| abort_pulse | output | 1 | One-cycle transmit-abort indication |

## Verification
The hardest state to reach is a write that arrives while the controller is enabled, where exactly one of the three permitting conditions is missing. Only then does the dropped write differ from an accepted one. The bench sweeps all sixteen combinations of the four status inputs. For each combination it writes a distinctive pattern and reads it back, then restores a known value with the controller disabled. Persistence of general-call mode is probed by rewriting the address and the 10-bit bit while special stays set. Abort behaviour is probed with back-to-back reads, with writes, and with reads in non-general-call modes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int TGT_AW    = 10;
    localparam int BUS_DW    = 32;
    localparam int FIELD_W   = TGT_AW + 3;

    typedef struct packed {
        logic              ten_bit;
        logic              special;
        logic              sel_start;
        logic [TGT_AW-1:0] addr;
    } tgt_cfg_t;

    typedef enum logic [1:0] {
        HK_SEVEN = 2'd0,
        HK_TEN   = 2'd1,
        HK_GCALL = 2'd2,
        HK_SBYTE = 2'd3
    } hdr_kind_e;

    typedef struct packed {
        logic [7:0] b0;
        logic [7:0] b1;
        logic       two;
    } hdr_t;

    function automatic tgt_cfg_t unpack_cfg(input logic [BUS_DW-1:0] d);
        tgt_cfg_t c;
        c.addr      = d[TGT_AW-1:0];
        c.sel_start = d[TGT_AW];
        c.special   = d[TGT_AW+1];
        c.ten_bit   = d[TGT_AW+2];
        return c;
    endfunction

    function automatic logic [BUS_DW-1:0] pack_cfg(input tgt_cfg_t c);
        logic [BUS_DW-1:0] d;
        d = '0;
        d[FIELD_W-1:0] = c;
        return d;
    endfunction

    function automatic hdr_kind_e classify(input tgt_cfg_t c);
        if (c.special) return c.sel_start ? HK_SBYTE : HK_GCALL;
        return c.ten_bit ? HK_TEN : HK_SEVEN;
    endfunction

endpackage

// File: rtl/tgt_wr_gate.sv
module tgt_wr_gate #(
    parameter int                BUS_AW     = 8,
    parameter logic [BUS_AW-1:0] REG_OFFSET = 8'h04
) (
    input  logic              reg_wr,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic              ctl_en,
    input  logic              mst_mode,
    input  logic              mst_busy,
    input  logic              txf_empty,
    output logic              hit,
    output logic              commit
);
    logic idle_master;

    always_comb begin
        hit         = (reg_addr == REG_OFFSET);
        idle_master = mst_mode && !mst_busy && txf_empty;
        commit      = reg_wr && hit && (!ctl_en || idle_master);
    end
endmodule

// File: rtl/tgt_cfg_reg.sv
module tgt_cfg_reg
    import i2c_tgt_pkg::*;
#(
    parameter logic [TGT_AW-1:0] RST_ADDR = 10'h055,
    parameter logic              RST_TEN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              wr_attempt,
    input  logic              blocked,
    input  logic [BUS_DW-1:0] wdata,
    output tgt_cfg_t          cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.addr      <= RST_ADDR;
            cfg.sel_start <= 1'b0;
            cfg.special   <= 1'b0;
            cfg.ten_bit   <= RST_TEN;
        end else if (commit) begin
            cfg <= unpack_cfg(wdata);
        end
    end

    AST_BLOCKED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_attempt && blocked) |=> $stable(cfg)); // R4
endmodule

// File: rtl/tgt_hdr_gen.sv
module tgt_hdr_gen
    import i2c_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tgt_cfg_t cfg,
    input  logic     rw,
    output hdr_t     hdr,
    output logic     gcall
);
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    hdr_kind_e kind;

    always_comb begin
        kind   = classify(cfg);
        gcall  = (kind == HK_GCALL);
        hdr    = '0;
        unique case (kind)
            HK_SEVEN: hdr.b0 = {cfg.addr[6:0], rw};
            HK_TEN: begin
                hdr.b0  = {TEN_PREFIX, cfg.addr[TGT_AW-1:8], rw};
                hdr.b1  = cfg.addr[7:0];
                hdr.two = 1'b1;
            end
            HK_GCALL: hdr.b0 = 8'h00;
            HK_SBYTE: hdr.b0 = 8'h01;
            default:  hdr    = '0;
        endcase
    end

    AST_GCALL_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg.special && !cfg.sel_start) |-> (hdr.b0 == 8'h00 && !hdr.two)); // R8
    AST_TWO_HAS_PREFIX: assert property (@(posedge clk) disable iff (rst)
        hdr.two |-> (hdr.b0[7:3] == TEN_PREFIX && cfg.ten_bit)); // R7
endmodule

// File: rtl/i2c_tgt_addr_ctl.sv
module i2c_tgt_addr_ctl
    import i2c_tgt_pkg::*;
#(
    parameter int                BUS_AW     = 8,
    parameter logic [BUS_AW-1:0] REG_OFFSET = 8'h04,
    parameter logic [TGT_AW-1:0] RST_ADDR   = 10'h055,
    parameter logic              RST_TEN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic [BUS_DW-1:0] reg_wdata,
    output logic [BUS_DW-1:0] reg_rdata,
    input  logic              ctl_en,
    input  logic              mst_mode,
    input  logic              mst_busy,
    input  logic              txf_empty,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    output logic [7:0]        hdr_byte0,
    output logic [7:0]        hdr_byte1,
    output logic              hdr_two,
    output logic              gcall_mode,
    output logic              abort_pulse
);
    logic     hit;
    logic     commit;
    logic     blocked;
    tgt_cfg_t cfg;
    hdr_t     hdr;

    tgt_wr_gate #(.BUS_AW(BUS_AW), .REG_OFFSET(REG_OFFSET)) u_gate (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .ctl_en    (ctl_en),
        .mst_mode  (mst_mode),
        .mst_busy  (mst_busy),
        .txf_empty (txf_empty),
        .hit       (hit),
        .commit    (commit)
    );

    assign blocked = ctl_en && (!mst_mode || mst_busy || !txf_empty);

    tgt_cfg_reg #(.RST_ADDR(RST_ADDR), .RST_TEN(RST_TEN)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .wr_attempt (reg_wr && hit),
        .blocked    (blocked),
        .wdata      (reg_wdata),
        .cfg        (cfg)
    );

    tgt_hdr_gen u_hdr (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg),
        .rw    (cmd_read),
        .hdr   (hdr),
        .gcall (gcall_mode)
    );

    always_comb begin
        reg_rdata = (reg_rd && hit) ? pack_cfg(cfg) : '0;
        hdr_byte0 = hdr.b0;
        hdr_byte1 = hdr.b1;
        hdr_two   = hdr.two;
    end

    always_ff @(posedge clk) begin
        if (rst) abort_pulse <= 1'b0;
        else     abort_pulse <= cmd_valid && cmd_read && gcall_mode;
    end

    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[BUS_DW-1:FIELD_W] == '0); // R3
    AST_ABORT_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> $past(cmd_valid && cmd_read)); // R10
    AST_OFF_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !hit) |=> $stable(cfg)); // R5
endmodule

// File: tb/i2c_tgt_addr_ctl_bench.sv
`timescale 1ns/1ps
module i2c_tgt_addr_ctl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_addr = 8'h04;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ctl_en = 0, mst_mode = 0, mst_busy = 0, txf_empty = 1;
    logic        cmd_valid = 0, cmd_read = 0;
    logic [7:0]  hdr_byte0, hdr_byte1;
    logic        hdr_two, gcall_mode, abort_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    i2c_tgt_addr_ctl u_i2c_tgt_addr_ctl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctl_en(ctl_en), .mst_mode(mst_mode), .mst_busy(mst_busy),
        .txf_empty(txf_empty), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .hdr_byte0(hdr_byte0), .hdr_byte1(hdr_byte1), .hdr_two(hdr_two),
        .gcall_mode(gcall_mode), .abort_pulse(abort_pulse)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write at the given offset; the register is updated by the next sample point
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_addr = 8'h04;
    endtask

    function automatic logic [31:0] rd_now(input logic [7:0] a);
        return 32'(0);
    endfunction

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_rd = 1; reg_addr = a;
        #0.5 v = reg_rdata;
        reg_rd = 0; reg_addr = 8'h04;
    endtask

    task automatic cfg_off(input logic [31:0] d);
        ctl_en = 0;
        wr(8'h04, d);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset values
        rd(8'h04, v); chk(v, 32'h0000_1055, "R1 reset readback");
        chk({24'h0, hdr_byte0}, 32'h0000_00F0, "R1 reset header byte");
        chk({24'h0, hdr_byte1}, 32'h55, "R1 reset second byte");
        // R5 no read strobe gives zero
        #0.5 chk(reg_rdata, 32'h0, "R5 idle read data");

        // R2 / R3 write while disabled, reserved ignored
        cfg_off(32'hFFFF_FFFF);
        rd(8'h04, v); chk(v, 32'h0000_1FFF, "R2 R3 all-ones write");
        cfg_off(32'hABCD_E123);
        rd(8'h04, v); chk(v, 32'h0000_0123, "R2 R3 pattern write");

        // R5 other offsets
        for (int a = 0; a < 64; a += 4) begin
            if (a == 4) continue;
            wr(8'(a), 32'h0000_0FFF);
            rd(8'(a), v); chk(v, 32'h0, "R5 off-offset read zero");
            rd(8'h04, v); chk(v, 32'h0000_0123, "R5 off-offset write ignored");
        end

        // R4 sweep all status combinations
        for (int s = 0; s < 16; s++) begin
            logic en, mm, bz, fe, ok;
            logic [31:0] base, pat, exp;
            en = s[0]; mm = s[1]; bz = s[2]; fe = s[3];
            base = 32'h0000_0033;
            pat  = 32'h0000_1ACE | (32'(s) << 4);
            cfg_off(base);
            ctl_en = en; mst_mode = mm; mst_busy = bz; txf_empty = fe;
            wr(8'h04, pat);
            ok = !en || (mm && !bz && fe);
            exp = ok ? (pat & 32'h1FFF) : base;
            rd(8'h04, v); chk(v, exp, "R4 status-gated write");
        end
        ctl_en = 0; mst_mode = 1; mst_busy = 0; txf_empty = 1;

        // R6 7-bit sweep
        for (int i = 0; i < 1024; i += 3) begin
            logic [9:0] a;
            a = 10'(i * 7);
            cfg_off({22'h0, a});
            cmd_read = 0; #0.5;
            chk({24'h0, hdr_byte0}, {24'h0, a[6:0], 1'b0}, "R6 7-bit write header");
            chk({31'h0, hdr_two}, 32'h0, "R6 single byte");
            cmd_read = 1; #0.5;
            chk({24'h0, hdr_byte0}, {24'h0, a[6:0], 1'b1}, "R6 7-bit read header");
            cmd_read = 0;
        end

        // R7 10-bit full sweep
        for (int i = 0; i < 1024; i++) begin
            logic [9:0] a;
            a = 10'(i);
            cfg_off(32'h1000 | {22'h0, a});
            cmd_read = i[0]; #0.5;
            chk({24'h0, hdr_byte0}, {24'h0, 5'b11110, a[9:8], i[0]}, "R7 10-bit header");
            chk({24'h0, hdr_byte1}, {24'h0, a[7:0]}, "R7 10-bit second byte");
            chk({31'h0, hdr_two}, 32'h1, "R7 two-byte flag");
            cmd_read = 0;
        end

        // R8 general call, address ignored, persistence
        for (int i = 0; i < 8; i++) begin
            cfg_off(32'h0800 | (32'(i) << 12 & 32'h1000) | 32'(i * 97 & 10'h3FF));
            cmd_read = i[1]; #0.5;
            chk({24'h0, hdr_byte0}, 32'h0, "R8 general call byte");
            chk({30'h0, gcall_mode, hdr_two}, 32'h2, "R8 general call persists");
            cmd_read = 0;
        end
        cfg_off(32'h0000_0011);
        #0.5 chk({31'h0, gcall_mode}, 32'h0, "R8 cleared by special=0");
        chk({24'h0, hdr_byte0}, 32'h22, "R8 normal after clear");

        // R9 START byte
        for (int i = 0; i < 4; i++) begin
            cfg_off(32'h0C00 | (32'(i) << 12 & 32'h1000) | 32'(i * 211));
            cmd_read = i[1]; #0.5;
            chk({23'h0, hdr_two, hdr_byte0}, 32'h01, "R9 START byte");
            cmd_read = 0;
        end

        // R10 abort
        cfg_off(32'h0800);
        @(negedge clk); cmd_valid = 1; cmd_read = 0;
        @(negedge clk); chk({31'h0, abort_pulse}, 32'h0, "R10 write no abort");
        cmd_read = 1;
        @(negedge clk); chk({31'h0, abort_pulse}, 32'h1, "R10 read abort");
        cmd_valid = 0;
        @(negedge clk); chk({31'h0, abort_pulse}, 32'h0, "R10 single cycle");
        cmd_valid = 1; cmd_read = 1;
        @(negedge clk); chk({31'h0, abort_pulse}, 32'h1, "R10 back-to-back first");
        @(negedge clk); chk({31'h0, abort_pulse}, 32'h1, "R10 back-to-back second");
        cmd_valid = 0;
        @(negedge clk); chk({31'h0, abort_pulse}, 32'h0, "R10 ends");
        cmd_read = 1; cmd_valid = 1;
        @(negedge clk); chk({31'h0, abort_pulse}, 32'h1, "R10 pre-mode-change");
        cmd_valid = 0;
        cfg_off(32'h0C00);
        cmd_valid = 1;
        @(negedge clk); chk({31'h0, abort_pulse}, 32'h0, "R10 START mode no abort");
        cfg_off(32'h1055);
        @(negedge clk); chk({31'h0, abort_pulse}, 32'h0, "R10 10-bit read no abort");
        cmd_valid = 0; cmd_read = 0;
        v = rd_now(8'h04);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule